// File: doc/BRIEF.md
# Pin Bank Controller with Per-Pin Interrupt Triggers

This block controls one bank of up to eight general-purpose pins through a simple word-addressed register interface. Every pin has its own 32-byte register window. In that window the pin can be enabled, turned into an output, given a driven level or floated, and given an input debounce threshold. The window also sets the pin's interrupt trigger, its interrupt mask and a write-one acknowledge. The filtered input level can be read back from the window as well.

Pad inputs first pass through a multi-stage synchronizer and then through a per-pin debounce filter. A trigger detector then raises a pending flag for each pin. A pending flag set by an edge trigger stays set until software acknowledges it. A pending flag in level mode tracks the qualified input level. A bank status word gathers every pending flag. The single interrupt line is the OR of the pending flags that are unmasked.

Top module: `pin_bank_ctrl`

## Requirements
- R1: Pin p's window begins at byte address p*0x20, with word offsets config 0x00, debounce 0x04, input 0x08, float 0x0C, output value 0x10 and acknowledge 0x14. The config word reads back only bit 0 (enable), bit 1 (output), bits 3:2 (trigger mode), bit 4 (polarity) and bit 6 (irq enable); every other bit reads 0. The debounce word keeps bits 7:0. A window for a pin at or above NUM_PINS ignores writes and reads 0.
- R2: After reset every config word is 0, the float bit is 1, the output value is 0, pad_oe and irq_out are low and the status word is 0.
- R3: pad_oe[p] is high only while pin p is enabled, set to output and not floated. pad_out[p] carries bit 0 of the output value register.
- R4: The input word returns the synchronized, debounced pad level in bit 0.
- R5: Trigger mode 2 is single edge. Polarity 1 detects rising edges and polarity 0 detects falling edges.
- R6: Trigger mode 3 detects both edges, whatever the polarity.
- R7: Trigger mode 1 is level. The pending flag follows the level match (polarity 1 means high, polarity 0 means low), so an acknowledge does not clear it while the level persists.
- R8: An edge-triggered pending flag stays set until a write with bit 0 = 1 to the pin's acknowledge word. A write of 0 there has no effect.
- R9: The status word at 0x100 + 4*STATUS_SLOT shows pin p's pending flag in bit p. Masked pins are included.
- R10: irq_out is high exactly when some pin has both its pending flag and its irq enable set. Masking a pin leaves its pending flag set.
- R11: A filtered level changes only after the synchronized input has differed from it for the debounce threshold in clock cycles. A threshold of 0 disables the filter.
- R12: A pin that is disabled, or whose trigger mode is 0, never holds a pending flag.
- R13: A read request returns its data with rd_valid in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | DATA_W | Read data |
| pad_in | input | NUM_PINS | Asynchronous pad input levels |
| pad_out | output | NUM_PINS | Levels driven to the pads |
| pad_oe | output | NUM_PINS | Pad output enables |
| irq_out | output | 1 | Bank interrupt |

## Verification
The bench builds the block with NUM_PINS = 6 and SYNC_STAGES = 3. With six pins, the windows for pins 6 and 7 still decode but lie beyond the bank, so the bench can show that writes there are dropped and that the status bits above pin 5 stay zero. The three-stage synchronizer lengthens the input path, so the debounce test measures its glitch and pulse lengths against the filter itself rather than against a shortest-case pipeline.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

   typedef enum logic [1:0] {
      TRIG_OFF   = 2'd0,
      TRIG_LEVEL = 2'd1,
      TRIG_EDGE  = 2'd2,
      TRIG_BOTH  = 2'd3
   } trig_mode_e;

   typedef struct packed {
      logic       irq_en;
      logic       polarity;
      trig_mode_e mode;
      logic       is_out;
      logic       enable;
   } pin_cfg_t;

   // config word bit positions
   localparam int CFG_EN_BIT   = 0;
   localparam int CFG_OUT_BIT  = 1;
   localparam int CFG_MODE_LSB = 2;
   localparam int CFG_POL_BIT  = 4;
   localparam int CFG_IE_BIT   = 6;

   // word index inside a pin window
   localparam logic [2:0] W_CFG   = 3'd0;
   localparam logic [2:0] W_DBNC  = 3'd1;
   localparam logic [2:0] W_IN    = 3'd2;
   localparam logic [2:0] W_FLOAT = 3'd3;
   localparam logic [2:0] W_OUT   = 3'd4;
   localparam logic [2:0] W_ACK   = 3'd5;

   localparam int WIN_LSB   = 5;
   localparam int PIN_IDX_W = 3;

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pinbank_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pinbank_debounce.sv
module pinbank_debounce #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             raw,
   input  logic [CNT_W-1:0] thresh,
   output logic             level
);
   localparam int EXT_W = CNT_W + 1;

   logic [CNT_W-1:0] run;
   logic [EXT_W-1:0] run_next;

   assign run_next = {1'b0, run} + EXT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run   <= '0;
         level <= 1'b0;
      end else if (raw == level) begin
         run <= '0;
      end else if (run_next >= {1'b0, thresh}) begin
         level <= raw;
         run   <= '0;
      end else begin
         run <= run_next[CNT_W-1:0];
      end
   end
endmodule

// File: rtl/pinbank_trigger.sv
module pinbank_trigger
   import pinbank_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     level,
   input  pin_cfg_t cfg,
   input  logic     ack,
   output logic     pending
);
   logic prev;
   logic rise, fall, hit, active;

   assign rise   = level & ~prev;
   assign fall   = ~level & prev;
   assign active = cfg.enable && (cfg.mode != TRIG_OFF);

   always_comb begin
      unique case (cfg.mode)
         TRIG_EDGE: hit = cfg.polarity ? rise : fall;
         TRIG_BOTH: hit = rise | fall;
         default:   hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev    <= 1'b0;
         pending <= 1'b0;
      end else begin
         prev <= level;
         if (!active)
            pending <= 1'b0;
         else if (cfg.mode == TRIG_LEVEL)
            pending <= (level == cfg.polarity);
         else
            pending <= (pending & ~ack) | hit;   // a new edge wins over a clear
      end
   end
endmodule

// File: rtl/pin_bank_ctrl.sv
module pin_bank_ctrl
   import pinbank_pkg::*;
#(
   parameter int NUM_PINS    = 8,
   parameter int SYNC_STAGES = 2,
   parameter int DBNC_W      = 8,
   parameter int ADDR_W      = 9,
   parameter int DATA_W      = 32,
   parameter int STATUS_SLOT = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DATA_W-1:0]   req_wdata,
   output logic                rd_valid,
   output logic [DATA_W-1:0]   rd_data,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic                irq_out
);
   localparam int STATUS_BYTE = 'h100 + 4 * STATUS_SLOT;
   localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(STATUS_BYTE);

   if (NUM_PINS < 1 || NUM_PINS > 8) begin : g_bad_pins
      $error("pin_bank_ctrl: NUM_PINS must be 1..8");
   end
   if (ADDR_W < 9 || STATUS_SLOT < 0 || STATUS_SLOT > 63) begin : g_bad_addr
      $error("pin_bank_ctrl: address map does not fit");
   end
   if (DATA_W < 8 || DBNC_W < 1 || DBNC_W > 8) begin : g_bad_data
      $error("pin_bank_ctrl: DATA_W >= 8 and DBNC_W in 1..8 required");
   end

   // ---------------- register state ----------------
   pin_cfg_t          cfg_q  [NUM_PINS];
   logic [DBNC_W-1:0] dbnc_q [NUM_PINS];
   logic [NUM_PINS-1:0] float_q, outv_q;

   // ---------------- decode ----------------
   logic                 win_hit, stat_hit, wr_en, rd_en;
   logic [PIN_IDX_W-1:0] pin_idx;
   logic [2:0]           word;

   assign pin_idx  = req_addr[WIN_LSB +: PIN_IDX_W];
   assign word     = req_addr[4:2];
   assign win_hit  = (req_addr >> 8) == '0;
   assign stat_hit = req_addr == STATUS_ADDR;
   assign wr_en    = req_valid & req_write;
   assign rd_en    = req_valid & ~req_write;

   logic unused_bits;
   assign unused_bits = ^{req_wdata[DATA_W-1:8], req_addr[1:0]};

   // ---------------- per-pin datapath ----------------
   logic [NUM_PINS-1:0] pin_sync, pin_level, pend, ack_pulse;
   logic [NUM_PINS-1:0] cfg_en, cfg_out, ie_vec, trig_off, edge_arm;

   pinbank_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pad_in),
      .q    (pin_sync)
   );

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      logic sel;
      assign sel = win_hit && (pin_idx == PIN_IDX_W'(p));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg_q[p]   <= '{irq_en: 1'b0, polarity: 1'b0, mode: TRIG_OFF,
                            is_out: 1'b0, enable: 1'b0};
            dbnc_q[p]  <= '0;
            float_q[p] <= 1'b1;
            outv_q[p]  <= 1'b0;
         end else if (wr_en && sel) begin
            unique case (word)
               W_CFG: cfg_q[p] <= '{irq_en:   req_wdata[CFG_IE_BIT],
                                    polarity: req_wdata[CFG_POL_BIT],
                                    mode:     trig_mode_e'(req_wdata[CFG_MODE_LSB +: 2]),
                                    is_out:   req_wdata[CFG_OUT_BIT],
                                    enable:   req_wdata[CFG_EN_BIT]};
               W_DBNC:  dbnc_q[p]  <= req_wdata[DBNC_W-1:0];
               W_FLOAT: float_q[p] <= req_wdata[0];
               W_OUT:   outv_q[p]  <= req_wdata[0];
               default: ;
            endcase
         end
      end

      assign ack_pulse[p] = wr_en && sel && (word == W_ACK) && req_wdata[0];

      pinbank_debounce #(.CNT_W(DBNC_W)) u_dbnc (
         .clk   (clk),
         .rst_n (rst_n),
         .raw   (pin_sync[p]),
         .thresh(dbnc_q[p]),
         .level (pin_level[p])
      );

      pinbank_trigger u_trig (
         .clk    (clk),
         .rst_n  (rst_n),
         .level  (pin_level[p]),
         .cfg    (cfg_q[p]),
         .ack    (ack_pulse[p]),
         .pending(pend[p])
      );

      assign cfg_en[p]   = cfg_q[p].enable;
      assign cfg_out[p]  = cfg_q[p].is_out;
      assign ie_vec[p]   = cfg_q[p].irq_en;
      assign trig_off[p] = cfg_q[p].mode == TRIG_OFF;
      assign edge_arm[p] = cfg_q[p].enable &&
                           (cfg_q[p].mode == TRIG_EDGE || cfg_q[p].mode == TRIG_BOTH);
      assign pad_oe[p]   = cfg_q[p].enable & cfg_q[p].is_out & ~float_q[p];
      assign pad_out[p]  = outv_q[p];
   end

   assign irq_out = |(pend & ie_vec);

   // ---------------- read path ----------------
   logic [DATA_W-1:0] rdata_nxt;

   always_comb begin
      rdata_nxt = '0;
      if (stat_hit) begin
         rdata_nxt[NUM_PINS-1:0] = pend;
      end else if (win_hit) begin
         for (int p = 0; p < NUM_PINS; p++) begin
            if (pin_idx == PIN_IDX_W'(p)) begin
               unique case (word)
                  W_CFG: begin
                     rdata_nxt[CFG_EN_BIT]            = cfg_q[p].enable;
                     rdata_nxt[CFG_OUT_BIT]           = cfg_q[p].is_out;
                     rdata_nxt[CFG_MODE_LSB +: 2]     = cfg_q[p].mode;
                     rdata_nxt[CFG_POL_BIT]           = cfg_q[p].polarity;
                     rdata_nxt[CFG_IE_BIT]            = cfg_q[p].irq_en;
                  end
                  W_DBNC:  rdata_nxt[DBNC_W-1:0] = dbnc_q[p];
                  W_IN:    rdata_nxt[0]          = pin_level[p];
                  W_FLOAT: rdata_nxt[0]          = float_q[p];
                  W_OUT:   rdata_nxt[0]          = outv_q[p];
                  default: ;
               endcase
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) rd_data <= rdata_nxt;
      end
   end
endmodule

// File: rtl/pin_bank_ctrl_chk.sv
module pin_bank_ctrl_chk #(
   parameter int NUM_PINS = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic                req_write,
   input logic                rd_valid,
   input logic                irq_out,
   input logic [NUM_PINS-1:0] pad_oe,
   input logic [NUM_PINS-1:0] cfg_en,
   input logic [NUM_PINS-1:0] cfg_out,
   input logic [NUM_PINS-1:0] float_q,
   input logic [NUM_PINS-1:0] trig_off,
   input logic [NUM_PINS-1:0] edge_arm,
   input logic [NUM_PINS-1:0] pend,
   input logic [NUM_PINS-1:0] ie_vec,
   input logic [NUM_PINS-1:0] ack_pulse
);
   // R13
   rd_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> rd_valid);

   // R13
   rd_only_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && !req_write) |=> !rd_valid);

   // R10
   masked_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ie_vec == '0) |-> !irq_out);

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
      // R3
      oe_needs_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
         pad_oe[p] |-> (cfg_en[p] && cfg_out[p] && !float_q[p]));

      // R12
      idle_no_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (trig_off[p] || !cfg_en[p]) |=> !pend[p]);

      // R8
      edge_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (edge_arm[p] && pend[p] && !ack_pulse[p]) |=> (pend[p] || !edge_arm[p]));
   end
endmodule

bind pin_bank_ctrl pin_bank_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_valid(req_valid),
   .req_write(req_write),
   .rd_valid (rd_valid),
   .irq_out  (irq_out),
   .pad_oe   (pad_oe),
   .cfg_en   (cfg_en),
   .cfg_out  (cfg_out),
   .float_q  (float_q),
   .trig_off (trig_off),
   .edge_arm (edge_arm),
   .pend     (pend),
   .ie_vec   (ie_vec),
   .ack_pulse(ack_pulse)
);

// File: tb/pin_bank_ctrl_test.sv
module pin_bank_ctrl_test;
   localparam int CLK_NS = 10;
   localparam int NP     = 6;
   localparam int AW     = 9;
   localparam int DW     = 32;
   localparam logic [AW-1:0] STAT = 9'h104;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          rd_valid;
   logic [DW-1:0] rd_data;
   logic [NP-1:0] pad_in = '0, pad_out, pad_oe;
   logic          irq_out;

   int checks = 0, errors = 0;
   bit done = 0;

   typedef struct { logic [DW-1:0] exp; string tag; } item_t;
   item_t sb_q[$];

   always #(CLK_NS/2) clk = ~clk;

   pin_bank_ctrl #(.NUM_PINS(NP), .SYNC_STAGES(3), .ADDR_W(AW), .DATA_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
      .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
      .irq_out(irq_out)
   );

   task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops the scoreboard as read data appears (R13)
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (sb_q.size() == 0) begin
            chk(rd_data, 32'hx, "R13 unexpected read data");
         end else begin
            item_t it;
            it = sb_q.pop_front();
            chk(rd_data, it.exp, it.tag);
         end
      end
   end

   function automatic logic [AW-1:0] pa(input int pin, input int w);
      return AW'(pin * 32 + w * 4);
   endfunction

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 0; req_write = 0;
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
      item_t it;
      it.exp = e; it.tag = tag;
      @(negedge clk);
      sb_q.push_back(it);
      req_valid = 1; req_write = 0; req_addr = a;
      @(negedge clk);
      req_valid = 0;
   endtask

   initial begin
      #(CLK_NS * 200000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      wait_cyc(3);
      rst_n = 1;
      wait_cyc(2);

      // R2 reset state
      rd(pa(0,0), 32'h0, "R2 config after reset");
      rd(pa(0,3), 32'h1, "R2 float after reset");
      rd(pa(0,4), 32'h0, "R2 output value after reset");
      rd(STAT, 32'h0, "R2 status after reset");
      chk({31'b0, irq_out}, 32'h0, "R2 irq after reset");
      chk(DW'(pad_oe), 32'h0, "R2 pad_oe after reset");

      // R1 decode and field masking
      wr(pa(3,0), 32'hFFFF_FFFF);
      rd(pa(3,0), 32'h5F, "R1 config readback mask");
      wr(pa(3,0), 32'h0);
      wr(pa(3,1), 32'h1FF);
      rd(pa(3,1), 32'hFF, "R1 debounce width");
      wr(pa(3,1), 32'h0);
      wr(pa(7,0), 32'hFF);
      rd(pa(7,0), 32'h0, "R1 window beyond bank");

      // R3 output drive
      wr(pa(1,4), 32'h1);
      wr(pa(1,0), 32'h3);
      chk(DW'(pad_oe[1]), 32'h0, "R3 floated pin not driven");
      wr(pa(1,3), 32'h0);
      chk(DW'(pad_oe[1]), 32'h1, "R3 output enable");
      chk(DW'(pad_out[1]), 32'h1, "R3 output level high");
      wr(pa(1,4), 32'h0);
      chk(DW'(pad_out[1]), 32'h0, "R3 output level low");
      wr(pa(1,0), 32'h1);
      chk(DW'(pad_oe[1]), 32'h0, "R3 input pin not driven");

      // R4 input readback
      pad_in[0] = 1; wait_cyc(10);
      rd(pa(0,2), 32'h1, "R4 input high");
      pad_in[0] = 0; wait_cyc(10);
      rd(pa(0,2), 32'h0, "R4 input low");

      // R5 single edge, rising
      wr(pa(0,0), 32'h59);
      pad_in[0] = 1; wait_cyc(10);
      rd(STAT, 32'h1, "R5 rising edge pending");
      chk(DW'(irq_out), 32'h1, "R10 irq on unmasked pending");
      // R8 write of zero keeps flag
      wr(pa(0,5), 32'h0);
      rd(STAT, 32'h1, "R8 zero ack ignored");
      wr(pa(0,5), 32'h1);
      rd(STAT, 32'h0, "R8 ack clears edge pending");
      pad_in[0] = 0; wait_cyc(10);
      rd(STAT, 32'h0, "R5 falling ignored with polarity 1");
      // R5 falling polarity
      wr(pa(0,0), 32'h49);
      pad_in[0] = 1; wait_cyc(10);
      rd(STAT, 32'h0, "R5 rising ignored with polarity 0");
      pad_in[0] = 0; wait_cyc(10);
      rd(STAT, 32'h1, "R5 falling edge pending");
      wr(pa(0,5), 32'h1);

      // R6 both edges
      wr(pa(0,0), 32'h4D);
      pad_in[0] = 1; wait_cyc(10);
      rd(STAT, 32'h1, "R6 rise in both-edge mode");
      wr(pa(0,5), 32'h1);
      pad_in[0] = 0; wait_cyc(10);
      rd(STAT, 32'h1, "R6 fall in both-edge mode");
      wr(pa(0,5), 32'h1);
      wr(pa(0,0), 32'h0);

      // R7 level mode on pin 4
      wr(pa(4,0), 32'h55);
      pad_in[4] = 1; wait_cyc(10);
      rd(STAT, 32'h10, "R7 level high pending");
      wr(pa(4,5), 32'h1); wait_cyc(3);
      rd(STAT, 32'h10, "R7 level reasserts after ack");
      pad_in[4] = 0; wait_cyc(10);
      rd(STAT, 32'h0, "R7 level drops with input");
      wr(pa(4,0), 32'h45); wait_cyc(3);
      rd(STAT, 32'h10, "R7 active-low level pending");
      // R12 trigger mode none clears
      wr(pa(4,0), 32'h41); wait_cyc(3);
      rd(STAT, 32'h0, "R12 mode none holds no pending");

      // R9/R10 masked pending
      wr(pa(0,0), 32'h19);
      pad_in[0] = 1; wait_cyc(10);
      rd(STAT, 32'h1, "R9 masked pin shows in status");
      chk(DW'(irq_out), 32'h0, "R10 masked pin no irq");
      wr(pa(0,0), 32'h59);
      chk(DW'(irq_out), 32'h1, "R10 unmask raises irq");
      wr(pa(0,0), 32'h19);
      chk(DW'(irq_out), 32'h0, "R10 remask drops irq");
      rd(STAT, 32'h1, "R10 masking keeps pending");
      wr(pa(0,5), 32'h1);
      pad_in[0] = 0;
      wr(pa(0,0), 32'h0);

      // R12 disabled pin
      wr(pa(5,0), 32'h58);
      pad_in[5] = 1; wait_cyc(10);
      rd(STAT, 32'h0, "R12 disabled pin no pending");
      pad_in[5] = 0;

      // R11 debounce on pin 2, threshold 6
      wr(pa(2,1), 32'h6);
      wr(pa(2,0), 32'h59);
      pad_in[2] = 1; wait_cyc(3); pad_in[2] = 0; wait_cyc(15);
      rd(STAT, 32'h0, "R11 short glitch rejected");
      rd(pa(2,2), 32'h0, "R11 glitch not seen on input");
      pad_in[2] = 1; wait_cyc(14);
      rd(STAT, 32'h4, "R11 long pulse accepted");
      rd(pa(2,2), 32'h1, "R4 filtered input high");
      chk(DW'(irq_out), 32'h1, "R10 irq from pin 2");

      wait_cyc(4);
      chk(DW'(sb_q.size()), 32'h0, "R13 every read answered");
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule